// File: doc/BRIEF.md
# Constant-Load Verification Buffer

This block keeps a small associative record of loads that the value predictor has marked as constant. It lets those loads be checked without a memory access. When such a load is dispatched, its data address and its prediction-table index are written into the buffer. Every executed store presents its address on a snoop port, and each record with that address is dropped. When the constant load later reaches its check point, the verify port reports whether its address-and-index pair is still held. A hit means no intervening store touched the location. A miss means the prediction cannot be trusted and the pipeline must squash.

Slots are filled in ring order. When every slot is occupied, a new record overwrites the oldest one. A full indicator shows when all slots hold live records. Inserting a pair that is already held does not take a second slot. The verify answer is combinational, so it is valid in the same cycle as the request.

Top module: `const_verify_buf`

## Requirements
- R1: After reset, no slot holds a record, `full` is low, and any verify request misses, including one for address 0 and index 0.
- R2: After an insert of an address-and-index pair has been clocked in, a verify of the same pair reports `vfyHit` high and `vfyMiss` low in the same cycle as the request.
- R3: A verify misses when only the address matches a held record (different index) or only the index matches (different address). Matching is exact on all 64 address bits and all index bits.
- R4: A snoop clocked in with a store address removes every record holding that address, however many there are. Records with other addresses stay held.
- R5: When a snoop and a verify present the same address in the same cycle, the verify reports a miss. From the next cycle on, the record is gone.
- R6: `full` is high exactly when all DEPTH slots hold live records. It drops after a snoop removes any of them.
- R7: When the buffer is full, an insert of a new pair evicts the oldest record, counted in insertion order since reset. All other records are kept.
- R8: Inserting a pair that is already held creates no second record and uses no slot.
- R9: While `vfyValid` is low, `vfyHit` and `vfyMiss` are both low. While it is high, exactly one of them is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Record a constant load this cycle |
| insAddr | input | ADDR_W (64) | Data address of the load being recorded |
| insIdx | input | IDX_W (10) | Prediction-table index of the load being recorded |
| snpValid | input | 1 | A store address is presented this cycle |
| snpAddr | input | ADDR_W (64) | Store data address to invalidate |
| vfyValid | input | 1 | Verify request this cycle |
| vfyAddr | input | ADDR_W (64) | Data address of the load being checked |
| vfyIdx | input | IDX_W (10) | Prediction-table index of the load being checked |
| vfyHit | output | 1 | The pair is held (prediction confirmed) |
| vfyMiss | output | 1 | The pair is absent (squash required) |
| full | output | 1 | All slots hold live records |

## Verification
The hardest state to reach is a full buffer whose oldest record is the next victim while a duplicate pair is also presented. Only an exact fill sequence from reset makes the victim slot known at the ports. The bench resets, inserts DEPTH-1 distinct pairs, and re-inserts the first pair to show that no slot was used. It then adds the last pair to raise `full`, inserts a fresh pair, and probes the first two pairs to show which one was evicted. The clash between a snoop and a verify in the same cycle is reached by driving both ports in one cycle. A later verify then confirms that the record was removed.

// File: rtl/cvb_pkg.sv
package cvb_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;   // write insert pair into slot wrSlot
    logic clrEn;  // clear every slot whose address matches the snoop
  } cvbStrobe_t;
endpackage

// File: rtl/cvb_dpath.sv
module cvb_dpath
  import cvb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 10,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cvbStrobe_t        strobe,
  input  logic [PTR_W-1:0]  wrSlot,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [IDX_W-1:0]  insIdx,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic [ADDR_W-1:0] vfyAddr,
  input  logic [IDX_W-1:0]  vfyIdx,
  output logic [DEPTH-1:0]  insHitVec,
  output logic [DEPTH-1:0]  snpHitVec,
  output logic [DEPTH-1:0]  vfyHitVec,
  output logic [DEPTH-1:0]  validVec
);
  logic [ADDR_W-1:0] addrMem [DEPTH];
  logic [IDX_W-1:0]  idxMem  [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic selWr;
    assign selWr = strobe.wrEn && (wrSlot == PTR_W'(g));

    // parallel compare against each slot
    assign insHitVec[g] = validVec[g] && (addrMem[g] == insAddr) && (idxMem[g] == insIdx);
    assign snpHitVec[g] = validVec[g] && (addrMem[g] == snpAddr);
    assign vfyHitVec[g] = validVec[g] && (addrMem[g] == vfyAddr) && (idxMem[g] == vfyIdx);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validVec[g] <= 1'b0;
      end else if (selWr) begin
        validVec[g] <= 1'b1;
      end else if (strobe.clrEn && snpHitVec[g]) begin
        validVec[g] <= 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrMem[g] <= '0;
        idxMem[g]  <= '0;
      end else if (selWr) begin
        addrMem[g] <= insAddr;
        idxMem[g]  <= insIdx;
      end
    end
  end
endmodule

// File: rtl/cvb_ctrl.sv
module cvb_ctrl
  import cvb_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             snpValid,
  input  logic             vfyValid,
  input  logic [DEPTH-1:0] insHitVec,
  input  logic [DEPTH-1:0] snpHitVec,
  input  logic [DEPTH-1:0] vfyHitVec,
  input  logic [DEPTH-1:0] validVec,
  output cvbStrobe_t       strobe,
  output logic [PTR_W-1:0] wrSlot,
  output logic             vfyHit,
  output logic             vfyMiss,
  output logic             full
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DEPTH-1:0] killVec;
  logic             dupHeld;
  logic [PTR_W-1:0] wrPtr;

  // slots a same-cycle store takes away
  assign killVec = snpValid ? snpHitVec : '0;
  // a duplicate counts only if it survives this cycle's snoop
  assign dupHeld = |(insHitVec & ~killVec);

  always_comb begin
    strobe.wrEn  = insValid && !dupHeld;
    strobe.clrEn = snpValid;
  end

  assign wrSlot = wrPtr;

  always_ff @(posedge clk) begin
    if (!rstN)            wrPtr <= '0;
    else if (strobe.wrEn) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
  end

  assign vfyHit  = vfyValid && |(vfyHitVec & ~killVec);
  assign vfyMiss = vfyValid && !vfyHit;
  assign full    = &validVec;
endmodule

// File: rtl/const_verify_buf.sv
module const_verify_buf
  import cvb_pkg::*;
#(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 10,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [IDX_W-1:0]  insIdx,
  input  logic              snpValid,
  input  logic [ADDR_W-1:0] snpAddr,
  input  logic              vfyValid,
  input  logic [ADDR_W-1:0] vfyAddr,
  input  logic [IDX_W-1:0]  vfyIdx,
  output logic              vfyHit,
  output logic              vfyMiss,
  output logic              full
);
  cvbStrobe_t       strobe;
  logic [PTR_W-1:0] wrSlot;
  logic [DEPTH-1:0] insHitVec, snpHitVec, vfyHitVec, validVec;

  cvb_dpath #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrSlot(wrSlot),
    .insAddr(insAddr), .insIdx(insIdx), .snpAddr(snpAddr),
    .vfyAddr(vfyAddr), .vfyIdx(vfyIdx),
    .insHitVec(insHitVec), .snpHitVec(snpHitVec),
    .vfyHitVec(vfyHitVec), .validVec(validVec)
  );

  cvb_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .insValid(insValid), .snpValid(snpValid),
    .vfyValid(vfyValid), .insHitVec(insHitVec), .snpHitVec(snpHitVec),
    .vfyHitVec(vfyHitVec), .validVec(validVec), .strobe(strobe),
    .wrSlot(wrSlot), .vfyHit(vfyHit), .vfyMiss(vfyMiss), .full(full)
  );
endmodule

// File: rtl/cvb_checker.sv
module cvb_checker #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              insValid,
  input logic              snpValid,
  input logic [ADDR_W-1:0] snpAddr,
  input logic              vfyValid,
  input logic [ADDR_W-1:0] vfyAddr,
  input logic              vfyHit,
  input logic              vfyMiss,
  input logic              full,
  input logic [DEPTH-1:0]  snpHitVec,
  input logic [DEPTH-1:0]  validVec
);
  // R9
  one_answer_chk: assert property (@(posedge clk) disable iff (!rstN)
    vfyValid |-> (vfyHit ^ vfyMiss));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !vfyValid |-> (!vfyHit && !vfyMiss));

  // R5
  snoop_beats_verify_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vfyValid && snpValid && (snpAddr == vfyAddr)) |-> !vfyHit);

  // R6
  full_needs_insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(full) |-> $past(insValid));

  // R4
  snoop_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && !insValid) |=> ((validVec & $past(snpHitVec)) == '0));
endmodule

bind const_verify_buf cvb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_cvb_checker (
  .clk(clk), .rstN(rstN), .insValid(insValid), .snpValid(snpValid),
  .snpAddr(snpAddr), .vfyValid(vfyValid), .vfyAddr(vfyAddr),
  .vfyHit(vfyHit), .vfyMiss(vfyMiss), .full(full),
  .snpHitVec(snpHitVec), .validVec(validVec)
);

// File: tb/test_const_verify_buf.sv
module test_const_verify_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 32;
  localparam int ADDR_W = 64;
  localparam int IDX_W  = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic insValid = 1'b0, snpValid = 1'b0, vfyValid = 1'b0;
  logic [ADDR_W-1:0] insAddr = '0, snpAddr = '0, vfyAddr = '0;
  logic [IDX_W-1:0]  insIdx = '0, vfyIdx = '0;
  logic vfyHit, vfyMiss, full;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  const_verify_buf #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_const_verify_buf (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insAddr(insAddr), .insIdx(insIdx),
    .snpValid(snpValid), .snpAddr(snpAddr), .vfyValid(vfyValid), .vfyAddr(vfyAddr),
    .vfyIdx(vfyIdx), .vfyHit(vfyHit), .vfyMiss(vfyMiss), .full(full)
  );

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic doInsert(input logic [ADDR_W-1:0] a, input logic [IDX_W-1:0] i);
    @(negedge clk);
    insValid = 1'b1; insAddr = a; insIdx = i;
    @(posedge clk); #1;
    insValid = 1'b0;
  endtask

  task automatic doSnoop(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    snpValid = 1'b1; snpAddr = a;
    @(posedge clk); #1;
    snpValid = 1'b0;
  endtask

  // verify, optionally with a same-cycle snoop; outputs sampled mid-cycle
  task automatic doVerify(input string req, input logic [ADDR_W-1:0] a,
                          input logic [IDX_W-1:0] i, input logic expHit,
                          input logic withSnoop);
    @(negedge clk);
    vfyValid = 1'b1; vfyAddr = a; vfyIdx = i;
    snpValid = withSnoop; snpAddr = a;
    #1;
    check(req, {vfyHit, vfyMiss}, {expHit, !expHit});
    @(posedge clk); #1;
    vfyValid = 1'b0; snpValid = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    #1;
    check("R1 full after reset", {1'b0, full}, 2'b00);
    doVerify("R1 zero pair after reset", '0, '0, 1'b0, 1'b0);
    #1;
    check("R9 idle outputs", {vfyHit, vfyMiss}, 2'b00);
  endtask

  task automatic testBasic();
    doInsert(64'hDEAD_BEEF_0000_1000, 10'd5);
    doVerify("R2 inserted pair hits", 64'hDEAD_BEEF_0000_1000, 10'd5, 1'b1, 1'b0);
    doVerify("R3 index differs", 64'hDEAD_BEEF_0000_1000, 10'd6, 1'b0, 1'b0);
    doVerify("R3 address differs in top bit", 64'h5EAD_BEEF_0000_1000, 10'd5, 1'b0, 1'b0);
  endtask

  task automatic testSnoopMulti();
    doInsert(64'h2000, 10'd1);
    doInsert(64'h2000, 10'd2);
    doInsert(64'h3000, 10'd3);
    doSnoop(64'h2000);
    doVerify("R4 first match removed", 64'h2000, 10'd1, 1'b0, 1'b0);
    doVerify("R4 second match removed", 64'h2000, 10'd2, 1'b0, 1'b0);
    doVerify("R4 other address kept", 64'h3000, 10'd3, 1'b1, 1'b0);
  endtask

  task automatic testSameCycle();
    doInsert(64'h4000, 10'd4);
    doVerify("R5 verify with same-cycle snoop", 64'h4000, 10'd4, 1'b0, 1'b1);
    doVerify("R5 record gone afterwards", 64'h4000, 10'd4, 1'b0, 1'b0);
  endtask

  task automatic testFillEvict();
    doReset();
    for (int k = 0; k < DEPTH - 1; k++) doInsert(64'(100 + k), IDX_W'(k));
    #1;
    check("R6 not full one short", {1'b0, full}, 2'b00);
    doInsert(64'd100, 10'd0);
    #1;
    check("R8 duplicate uses no slot", {1'b0, full}, 2'b00);
    doInsert(64'(100 + DEPTH - 1), IDX_W'(DEPTH - 1));
    #1;
    check("R6 full when all held", {1'b0, full}, 2'b01);
    doVerify("R8 duplicate left first record", 64'd100, 10'd0, 1'b1, 1'b0);
    doInsert(64'd999, 10'd7);
    doVerify("R7 oldest evicted", 64'd100, 10'd0, 1'b0, 1'b0);
    doVerify("R7 second oldest kept", 64'd101, 10'd1, 1'b1, 1'b0);
    doVerify("R7 new record held", 64'd999, 10'd7, 1'b1, 1'b0);
    #1;
    check("R6 still full after replace", {1'b0, full}, 2'b01);
    doSnoop(64'd105);
    #1;
    check("R6 full drops after snoop", {1'b0, full}, 2'b00);
  endtask

  initial begin
    testReset();
    testBasic();
    testSnoopMulti();
    testSameCycle();
    testFillEvict();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule